// File: doc/BRIEF.md
# Multi-Mode LED Charge Display Driver

This block drives a small LED gauge that shows how much charge a battery has left. It takes a relative state-of-charge value in percent (nominally 0 to 125), a first low-battery warning flag and a final empty flag. From these it produces the on/off drive for up to five LED segments and an enable for the shared LED common line. A three-level configuration pin, sampled once after reset, selects one of three ways to show the charge. Incremental mode lights a single segment out of four. Binary mode uses two segments. Bar mode uses a five-segment bar.

The display is dark until the host or a push-button pulls the active-low request input low. That starts a timed window, which lasts longer in incremental mode than in the other two. During the window, odd-numbered segments (SEG1, SEG3, SEG5) and even-numbered segments (SEG2, SEG4) are lit in two alternating slots of a short multiplex period. When the warning flag is set, the lowest segment blinks. When the empty flag is set, every segment goes dark. All timing counts a one-cycle clock-enable tick supplied from outside, so the block runs on any system clock.

Top module: `charge_led_disp`

## Requirements
- R1: The mode pin is decoded on the first rising clock edge after reset release: 2'b00 selects incremental, 2'b01 selects binary, 2'b10 or 2'b11 selects bar. Later changes of the pin have no effect until the next reset.
- R2: Incremental mode lights exactly one segment. seg_o[3] is lit for at least 90 percent, seg_o[2] for 50 to below 90, seg_o[1] for 20 to below 50, and seg_o[0] below 20. seg_o[4] is never lit.
- R3: Binary mode uses only seg_o[1:0]. Both are lit for at least 70 percent, only seg_o[0] for 40 to below 70, only seg_o[1] for 10 to below 40, and neither below 10. seg_o[4:2] are never lit.
- R4: Bar mode lights seg_o[k-1:0]. k is 5 for at least 80 percent, 4 for 60 to below 80, 3 for 40 to below 60, 2 for 20 to below 40, and 1 below 20.
- R5: Every band includes its lower bound. Any value above 100 shows the top band of the active mode.
- R6: The multiplex period is MUX_TICKS ticks. Segments with even index (seg_o[0], seg_o[2], seg_o[4]) may be lit only in the first BANK_ON_TICKS ticks of the period. Segments with odd index (seg_o[1], seg_o[3]) may be lit only in the BANK_ON_TICKS ticks that start at tick MUX_TICKS/2. The two groups are never lit in the same cycle.
- R7: In incremental and bar modes, while warn_i is high, seg_o[0] follows a blink that stays on for BLINK_TICKS ticks and off for BLINK_TICKS ticks, whatever the band. In binary mode warn_i has no effect.
- R8: While empty_i is high, all segments are off in every mode, from the first rising edge after empty_i is sampled high.
- R9: A high-to-low transition of disp_n_i opens a display window. The window lasts LONG_TICKS ticks in incremental mode and SHORT_TICKS ticks otherwise. com_en_o is high exactly during the window, and all segments are off outside it, including in reset.
- R10: A new request during an open window reloads the full window length.
- R11: com_en_o rises on the first rising edge that samples disp_n_i low after sampling it high. A change of the charge value or of the flags reaches seg_o one rising edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base clock enable, one cycle wide |
| mode_pin_i | input | 2 | Encoded three-level display mode configuration |
| soc_pct_i | input | PCT_W | Relative state of charge in percent |
| warn_i | input | 1 | First low-battery warning flag |
| empty_i | input | 1 | Final empty flag |
| disp_n_i | input | 1 | Active-low display request / disable |
| seg_o | output | 5 | Segment drive, 1 lights the segment, bit 0 is SEG1 |
| com_en_o | output | 1 | LED common enable, 1 while the display window is open |

## Verification
A request changes com_en_o after one rising edge, and a new charge value or flag changes seg_o after one rising edge. The bench drives stimulus on falling edges and reads results one or more falling edges later. Multiplexed results do not depend on the phase counter's alignment: the bench collects segment activity over whole multiplex periods, either OR-ing the pattern or counting lit cycles. Window length is counted in com_en_o high cycles after a single request or after two requests a known number of edges apart. Blinking is recognised because seg_o[0] is lit for fewer cycles over two blink half-periods than the steady count of a segment in the same group.

// File: rtl/cdisp_pkg.sv
package cdisp_pkg;

   typedef enum logic [1:0] {
      DM_INCR = 2'd0,
      DM_BIN  = 2'd1,
      DM_BAR  = 2'd2
   } disp_mode_e;

   localparam int NSEG = 5;

   // lower bounds of the bands, in percent
   localparam int INC_B3  = 90;
   localparam int INC_B2  = 50;
   localparam int INC_B1  = 20;
   localparam int BIN_HI  = 70;
   localparam int BIN_MID = 40;
   localparam int BIN_LO  = 10;
   localparam int BAR_B5  = 80;
   localparam int BAR_B4  = 60;
   localparam int BAR_B3  = 40;
   localparam int BAR_B2  = 20;

   // segments with even index share slot A, odd index slot B
   localparam logic [NSEG-1:0] SLOT_A_MASK = 5'b10101;
   localparam logic [NSEG-1:0] SLOT_B_MASK = 5'b01010;

   function automatic disp_mode_e decode_mode(input logic [1:0] pin);
      case (pin)
         2'b00:   return DM_INCR;
         2'b01:   return DM_BIN;
         default: return DM_BAR;
      endcase
   endfunction

endpackage

// File: rtl/cdisp_timebase.sv
module cdisp_timebase
   import cdisp_pkg::*;
#(
   parameter int MUX_TICKS     = 10,
   parameter int BANK_ON_TICKS = 3,
   parameter int BLINK_TICKS   = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic slot_a_o,
   output logic slot_b_o,
   output logic blink_o
);

   localparam int PH_W = $clog2(MUX_TICKS);
   localparam int BL_W = $clog2(BLINK_TICKS);
   localparam int HALF = MUX_TICKS / 2;

   initial begin
      assert (MUX_TICKS >= 2) else $error("MUX_TICKS must be at least 2");
      assert (BLINK_TICKS >= 2) else $error("BLINK_TICKS must be at least 2");
      assert (BANK_ON_TICKS >= 1 && 2 * BANK_ON_TICKS <= MUX_TICKS)
         else $error("BANK_ON_TICKS must fit twice in MUX_TICKS");
   end

   logic [PH_W-1:0] phase_q;
   logic [BL_W-1:0] bl_cnt_q;
   logic            blink_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= '0;
         bl_cnt_q <= '0;
         blink_q  <= 1'b1;
      end else if (tick_i) begin
         if (phase_q == PH_W'(MUX_TICKS - 1)) phase_q <= '0;
         else                                 phase_q <= phase_q + 1'b1;
         if (bl_cnt_q == BL_W'(BLINK_TICKS - 1)) begin
            bl_cnt_q <= '0;
            blink_q  <= ~blink_q;
         end else begin
            bl_cnt_q <= bl_cnt_q + 1'b1;
         end
      end
   end

   assign slot_a_o = ({1'b0, phase_q} < (PH_W + 1)'(BANK_ON_TICKS));
   assign slot_b_o = ({1'b0, phase_q} >= (PH_W + 1)'(HALF)) &&
                     ({1'b0, phase_q} <  (PH_W + 1)'(HALF + BANK_ON_TICKS));
   assign blink_o  = blink_q;

   // R7: blink phase moves only on a tick
   assert_blink_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(blink_q));

   // R6: the multiplex phase never stalls while ticks arrive
   assert_phase_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> !$stable(phase_q));

endmodule

// File: rtl/cdisp_window.sv
module cdisp_window
   import cdisp_pkg::*;
#(
   parameter int LONG_TICKS  = 10000,
   parameter int SHORT_TICKS = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic req_n_i,
   input  logic long_sel_i,
   output logic active_o
);

   localparam int MAXLEN = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
   localparam int CW     = $clog2(MAXLEN + 1);

   initial begin
      assert (LONG_TICKS >= 1 && SHORT_TICKS >= 1)
         else $error("window lengths must be non-zero");
   end

   logic          req_q;
   logic          start;
   logic [CW-1:0] cnt_q;

   assign start = req_q & ~req_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         req_q <= req_n_i;
         if (start)
            cnt_q <= long_sel_i ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);
         else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = (cnt_q != '0);

   // R9: a request always opens the window on the next edge
   assert_start_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> active_o);

   // R10: without a new request the window only counts down
   assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !start && tick_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cdisp_pattern.sv
module cdisp_pattern
   import cdisp_pkg::*;
#(
   parameter int PCT_W = 7
) (
   input  disp_mode_e        mode_i,
   input  logic [PCT_W-1:0]  pct_i,
   input  logic              warn_i,
   input  logic              empty_i,
   input  logic              blink_i,
   output logic [NSEG-1:0]   pat_o
);

   initial begin
      assert (PCT_W >= 7 && PCT_W <= 16) else $error("PCT_W must be 7 to 16");
   end

   logic [NSEG-1:0] base;
   int unsigned     pv;

   always_comb begin
      pv   = int'(pct_i);
      base = '0;
      unique case (mode_i)
         DM_INCR: begin
            if      (pv >= INC_B3) base[3] = 1'b1;
            else if (pv >= INC_B2) base[2] = 1'b1;
            else if (pv >= INC_B1) base[1] = 1'b1;
            else                   base[0] = 1'b1;
         end
         DM_BIN: begin
            if      (pv >= BIN_HI)  base[1:0] = 2'b11;
            else if (pv >= BIN_MID) base[0]   = 1'b1;
            else if (pv >= BIN_LO)  base[1]   = 1'b1;
         end
         default: begin
            base[0] = 1'b1;
            if (pv >= BAR_B2) base[1] = 1'b1;
            if (pv >= BAR_B3) base[2] = 1'b1;
            if (pv >= BAR_B4) base[3] = 1'b1;
            if (pv >= BAR_B5) base[4] = 1'b1;
         end
      endcase
      if (warn_i && mode_i != DM_BIN) base[0] = blink_i;
      if (empty_i) base = '0;
      pat_o = base;
   end

endmodule

// File: rtl/charge_led_disp.sv
module charge_led_disp
   import cdisp_pkg::*;
#(
   parameter int PCT_W         = 7,
   parameter int MUX_TICKS     = 10,
   parameter int BANK_ON_TICKS = 3,
   parameter int BLINK_TICKS   = 125,
   parameter int LONG_TICKS    = 10000,
   parameter int SHORT_TICKS   = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [1:0]       mode_pin_i,
   input  logic [PCT_W-1:0] soc_pct_i,
   input  logic             warn_i,
   input  logic             empty_i,
   input  logic             disp_n_i,
   output logic [4:0]       seg_o,
   output logic             com_en_o
);

   disp_mode_e      mode_q;
   logic            cfg_done_q;
   logic [NSEG-1:0] pat_d, pat_q;
   logic            slot_a, slot_b, blink, win_active;

   // configuration pin is read once, on the first edge out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= DM_BAR;
         cfg_done_q <= 1'b0;
      end else if (!cfg_done_q) begin
         mode_q     <= decode_mode(mode_pin_i);
         cfg_done_q <= 1'b1;
      end
   end

   cdisp_timebase #(
      .MUX_TICKS    (MUX_TICKS),
      .BANK_ON_TICKS(BANK_ON_TICKS),
      .BLINK_TICKS  (BLINK_TICKS)
   ) i_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .slot_a_o(slot_a),
      .slot_b_o(slot_b),
      .blink_o (blink)
   );

   cdisp_window #(
      .LONG_TICKS (LONG_TICKS),
      .SHORT_TICKS(SHORT_TICKS)
   ) i_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .req_n_i   (disp_n_i),
      .long_sel_i(mode_q == DM_INCR),
      .active_o  (win_active)
   );

   cdisp_pattern #(
      .PCT_W(PCT_W)
   ) i_pat (
      .mode_i (mode_q),
      .pct_i  (soc_pct_i),
      .warn_i (warn_i),
      .empty_i(empty_i),
      .blink_i(blink),
      .pat_o  (pat_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pat_q <= '0;
      else if (cfg_done_q) pat_q <= pat_d;
   end

   // per-segment slot gating: even index in slot A, odd index in slot B
   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      if (s % 2 == 0) begin : g_a
         assign seg_o[s] = pat_q[s] & win_active & slot_a;
      end else begin : g_b
         assign seg_o[s] = pat_q[s] & win_active & slot_b;
      end
   end

   assign com_en_o = win_active;

   // R6: the two slot groups never light together
   assert_slot_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !((|(seg_o & SLOT_A_MASK)) && (|(seg_o & SLOT_B_MASK))));

   // R9: dark whenever the common line is off
   assert_dark_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !com_en_o |-> (seg_o == '0));

   // R8: empty flag blanks on the next edge
   assert_empty_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      empty_i |=> (seg_o == '0));

   // R1: the latched mode never changes after the first edge
   assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done_q |=> $stable(mode_q));

   // R3: binary mode never uses the upper three segments
   assert_bin_two_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done_q && mode_q == DM_BIN) |-> (seg_o[4:2] == 3'b000));

   // R2: incremental mode never uses the fifth segment
   assert_incr_no_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done_q && mode_q == DM_INCR) |-> !seg_o[4]);

endmodule

// File: tb/test_charge_led_disp.sv
module test_charge_led_disp;

   localparam int MUX = 10;
   localparam int ON  = 3;
   localparam int BLK = 20;
   localparam int LNG = 200;
   localparam int SHT = 80;

   // 8-unit period: 125 MHz with 1 ns units
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic [1:0] mode_pin = 2'b00;
   logic [6:0] soc = '0;
   logic       warn = 1'b0;
   logic       empty = 1'b0;
   logic       disp_n = 1'b1;
   logic [4:0] seg;
   logic       com;

   int n_chk = 0;
   int n_bad = 0;
   int excl_viol = 0;
   bit finished = 1'b0;

   charge_led_disp #(
      .PCT_W(7), .MUX_TICKS(MUX), .BANK_ON_TICKS(ON), .BLINK_TICKS(BLK),
      .LONG_TICKS(LNG), .SHORT_TICKS(SHT)
   ) i_charge_led_disp (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_pin_i(mode_pin),
      .soc_pct_i(soc), .warn_i(warn), .empty_i(empty), .disp_n_i(disp_n),
      .seg_o(seg), .com_en_o(com)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mode: 0 incremental, 1 binary, 2 bar
   function automatic int exp_pat(input int mode, input int p);
      int n;
      if (mode == 0) begin
         if (p >= 90) return 8;
         if (p >= 50) return 4;
         if (p >= 20) return 2;
         return 1;
      end else if (mode == 1) begin
         if (p >= 70) return 3;
         if (p >= 40) return 1;
         if (p >= 10) return 2;
         return 0;
      end
      n = (p >= 80) ? 5 : (p >= 60) ? 4 : (p >= 40) ? 3 : (p >= 20) ? 2 : 1;
      return (1 << n) - 1;
   endfunction

   task automatic do_reset(input logic [1:0] code, input logic [1:0] later);
      rst_n = 1'b0; mode_pin = code; disp_n = 1'b1; warn = 1'b0; empty = 1'b0;
      repeat (3) @(negedge clk);
      chk(seg == 5'b0 && com == 1'b0, "R9 reset dark", int'({com, seg}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mode_pin = later;
   endtask

   task automatic press();
      disp_n = 1'b0;
      @(negedge clk);
      disp_n = 1'b1;
   endtask

   // OR of segments over n cycles, plus lit-cycle counts per segment
   task automatic observe(input int n, output logic [4:0] acc, output int c0,
                          output int c1, output int c2, output int ccom);
      acc = '0; c0 = 0; c1 = 0; c2 = 0; ccom = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         acc |= seg;
         if (seg[0]) c0++;
         if (seg[1]) c1++;
         if (seg[2]) c2++;
         if (com) ccom++;
         if ((|(seg & 5'b10101)) && (|(seg & 5'b01010))) excl_viol++;
      end
   endtask

   task automatic check_band(input int mode, input int p, input string req);
      logic [4:0] acc;
      int c0, c1, c2, cc;
      soc = 7'(p);
      press();
      @(negedge clk);
      observe(MUX, acc, c0, c1, c2, cc);
      chk(acc == 5'(exp_pat(mode, p)), req, int'(acc), exp_pat(mode, p));
   endtask

   task automatic sweep(input int mode, input string req);
      for (int p = 0; p < 128; p++)
         check_band(mode, p, (p > 100) ? "R5 above-full top band" : req);
   endtask

   task automatic window_len(input int expect_len, input string req);
      int cnt;
      repeat (LNG + 20) @(negedge clk);
      cnt = 0;
      disp_n = 1'b0;
      for (int i = 0; i < LNG + 50; i++) begin
         @(negedge clk);
         if (i == 0) disp_n = 1'b1;
         if (com) cnt++;
      end
      chk(cnt == expect_len, req, cnt, expect_len);
      chk(seg == 5'b0, "R9 dark after window", int'(seg), 0);
   endtask

   initial begin
      logic [4:0] acc;
      int c0, c1, c2, cc, cnt;

      // ---- incremental mode, pin changed after latch (R1)
      do_reset(2'b00, 2'b01);
      sweep(0, "R2 incremental band");
      check_band(0, 95, "R1 mode held after pin change");
      check_band(0, 90, "R5 lower bound inclusive");
      check_band(0, 89, "R2 just below bound");
      // R7 blink in incremental mode, R6 slot counts
      soc = 7'd30; warn = 1'b1;
      press(); @(negedge clk);
      observe(2 * BLK, acc, c0, c1, c2, cc);
      chk(c0 >= 3 && c0 <= 9, "R7 incremental SEG1 blinks", c0, 6);
      chk(c1 == 4 * ON, "R7 incremental band segment steady", c1, 4 * ON);
      warn = 1'b0;
      window_len(LNG, "R9 incremental window length");

      // ---- binary mode
      do_reset(2'b01, 2'b10);
      sweep(1, "R3 binary band");
      soc = 7'd100; warn = 1'b1;
      press(); @(negedge clk);
      observe(2 * BLK, acc, c0, c1, c2, cc);
      chk(c0 == 4 * ON, "R7 binary ignores warning", c0, 4 * ON);
      chk(c1 == 4 * ON, "R6 odd slot lit cycles", c1, 4 * ON);
      warn = 1'b0;
      window_len(SHT, "R9 binary window length");

      // ---- bar mode
      do_reset(2'b10, 2'b00);
      sweep(2, "R4 bar band");
      soc = 7'd100;
      press(); @(negedge clk);
      observe(MUX, acc, c0, c1, c2, cc);
      chk(c0 == ON, "R6 even slot lit cycles per period", c0, ON);
      chk(c1 == ON, "R6 odd slot lit cycles per period", c1, ON);
      warn = 1'b1;
      press(); @(negedge clk);
      observe(2 * BLK, acc, c0, c1, c2, cc);
      chk(c0 >= 3 && c0 <= 9, "R7 bar SEG1 blinks", c0, 6);
      chk(c2 == 4 * ON, "R7 bar SEG3 steady", c2, 4 * ON);
      warn = 1'b0;
      // R8 empty blanks
      empty = 1'b1;
      press(); @(negedge clk);
      observe(MUX, acc, c0, c1, c2, cc);
      chk(acc == 5'b0, "R8 empty blanks segments", int'(acc), 0);
      chk(cc == MUX, "R8 window still open while blank", cc, MUX);
      empty = 1'b0;
      window_len(SHT, "R9 bar window length");
      // R10 restart after 30 edges
      repeat (LNG + 20) @(negedge clk);
      cnt = 0;
      disp_n = 1'b0;
      for (int i = 0; i < LNG + 100; i++) begin
         @(negedge clk);
         if (i == 0) disp_n = 1'b1;
         if (i == 29) disp_n = 1'b0;
         if (i == 30) disp_n = 1'b1;
         if (com) cnt++;
      end
      chk(cnt == 30 + SHT, "R10 request restarts window", cnt, 30 + SHT);
      // R11 one-edge latency of the common enable
      repeat (SHT + 10) @(negedge clk);
      disp_n = 1'b0;
      #1;
      chk(com == 1'b0, "R11 common not early", int'(com), 0);
      @(negedge clk);
      chk(com == 1'b1, "R11 common after one edge", int'(com), 1);
      disp_n = 1'b1;
      // R11 empty reaches segments after one edge
      soc = 7'd100;
      repeat (2) @(negedge clk);
      empty = 1'b1;
      @(negedge clk);
      observe(MUX, acc, c0, c1, c2, cc);
      chk(acc == 5'b0, "R11 empty one edge later", int'(acc), 0);
      empty = 1'b0;

      // ---- code 2'b11 also selects bar
      do_reset(2'b11, 2'b00);
      check_band(2, 65, "R1 code 11 selects bar");
      check_band(2, 20, "R4 bar two-segment lower bound");

      chk(excl_viol == 0, "R6 slot groups exclusive", excl_viol, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      finished = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule